// File: doc/BRIEF.md
# Effective Address Unit

This unit turns an addressing-mode code and the fields of an instruction into the address of an operand. It holds a small register file, a program counter and the arithmetic needed to combine them. A one-cycle start strobe launches a calculation. Register-based modes return a result on the next cycle. Memory-indirect mode first reads a pointer word through a synchronous read port and then returns that word as the address. The unit applies the register updates of the post-increment and pre-decrement modes itself. It also reports each update on a write-back port so that the surrounding pipeline can follow the change.

Registers and the program counter are loaded through a plain write port. Addresses are `AW` bits wide and every sum wraps modulo 2^AW. A short displacement of `DISP_W` bits is sign-extended before it is added. The element size used by the auto modes is zero-extended. Mode codes 10 to 15 are not assigned and are handled as immediate.

Top module: `ea_unit`

## Requirements
- R1: Mode code 1 (direct) returns the address field unchanged on `ea_o`.
- R2: Mode code 2 (register indirect) returns the contents of the register chosen by `reg_sel_i`. A value loaded through the load port is returned by a later request.
- R3: Mode code 3 (post-increment) returns the register's current value. The register then becomes value + d, and that new value is shown on the write-back port and returned by later reads.
- R4: Mode code 4 (pre-decrement) returns value − d. The register is also left holding value − d, which is shown on the write-back port.
- R5: Mode code 5 (indexed) returns the register chosen by `idx_sel_i` plus the sign-extended `disp_i`.
- R6: Mode code 6 (base plus index) returns the register chosen by `base_sel_i` plus the register chosen by `idx_sel_i`.
- R7: Mode code 7 returns PC + address field. Mode code 8 returns the register chosen by `base_sel_i` + address field.
- R8: Mode code 9 (memory indirect) raises `mem_req_o` on the cycle after start, with `mem_addr_o` equal to the address field, and holds it until `mem_valid_i`. On the cycle after `mem_valid_i`, `done_o` is high and `ea_o` equals the returned word.
- R9: All additions and subtractions wrap modulo 2^AW.
- R10: Mode code 0 (immediate) sets `imm_o`, puts the address field on `ea_o` and performs no write-back.
- R11: For every mode except 9, `done_o` is high exactly on the cycle after start. `done_o` lasts one cycle, and `wb_en_o` is high only together with `done_o`.
- R12: A start strobe that arrives while a pointer read is outstanding is ignored. It produces no `done_o`, and it changes neither the register file nor the result.
- R13: After reset, `done_o`, `mem_req_o`, `wb_en_o`, `imm_o` and `ea_o` are all zero, and all registers and the PC read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_we_i | input | 1 | Load a register from `ld_data_i` |
| ld_sel_i | input | SEL_W | Register to load |
| ld_data_i | input | AW | Load value |
| pc_we_i | input | 1 | Load the program counter |
| pc_data_i | input | AW | Program counter value |
| start_i | input | 1 | Start strobe, one cycle |
| mode_i | input | 4 | Addressing-mode code |
| reg_sel_i | input | SEL_W | Register for indirect and auto modes |
| base_sel_i | input | SEL_W | Base register |
| idx_sel_i | input | SEL_W | Index register |
| addr_field_i | input | AW | Address field of the instruction |
| disp_i | input | DISP_W | Short signed displacement |
| elem_size_i | input | D_W | Element size d for the auto modes |
| mem_req_o | output | 1 | Pointer read outstanding |
| mem_addr_o | output | AW | Pointer read address |
| mem_valid_i | input | 1 | Pointer read data valid |
| mem_rdata_i | input | AW | Pointer read data |
| done_o | output | 1 | Result valid, one-cycle pulse |
| ea_o | output | AW | Effective address, or the operand when `imm_o` is set |
| imm_o | output | 1 | Result is an immediate operand |
| wb_en_o | output | 1 | Register update performed |
| wb_sel_o | output | SEL_W | Updated register |
| wb_data_o | output | AW | New register value |

## Verification
The bench uses the default parameters: eight 16-bit registers, an 8-bit displacement and a 4-bit element size. With 16-bit addresses, register values close to 0xFFFF are easy to set up. The stimulus therefore drives wrap-around through post-increment, pre-decrement from zero, base-plus-index overflow and a negative displacement. The memory model answers the pointer read only after several idle cycles. This leaves room to issue a competing start during the wait and confirm that it is discarded.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    MODE_IMM      = 4'd0,
    MODE_DIRECT   = 4'd1,
    MODE_REG_IND  = 4'd2,
    MODE_POST_INC = 4'd3,
    MODE_PRE_DEC  = 4'd4,
    MODE_INDEXED  = 4'd5,
    MODE_BASE_IDX = 4'd6,
    MODE_PC_REL   = 4'd7,
    MODE_BASE_REL = 4'd8,
    MODE_MEM_IND  = 4'd9
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ea_state_e;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int AW    = 16,
  parameter int NREGS = 8,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  logic [AW-1:0]    ld_data_i,
  input  logic             pc_we_i,
  input  logic [AW-1:0]    pc_data_i,
  input  logic             upd_we_i,
  input  logic [SEL_W-1:0] upd_sel_i,
  input  logic [AW-1:0]    upd_data_i,
  input  logic [SEL_W-1:0] rd_a_sel_i,
  input  logic [SEL_W-1:0] rd_b_sel_i,
  input  logic [SEL_W-1:0] rd_c_sel_i,
  output logic [AW-1:0]    rd_a_o,
  output logic [AW-1:0]    rd_b_o,
  output logic [AW-1:0]    rd_c_o,
  output logic [AW-1:0]    pc_o
);
  logic [AW-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    // auto-mode update wins over an external load of the same register
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[g] <= '0;
      else if (upd_we_i && upd_sel_i == SEL_W'(g))    regs_q[g] <= upd_data_i;
      else if (ld_we_i && ld_sel_i == SEL_W'(g))      regs_q[g] <= ld_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_o <= '0;
    else if (pc_we_i) pc_o <= pc_data_i;
  end

  assign rd_a_o = regs_q[rd_a_sel_i];
  assign rd_b_o = regs_q[rd_b_sel_i];
  assign rd_c_o = regs_q[rd_c_sel_i];
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DISP_W = 8,
  parameter int D_W    = 4
) (
  input  logic [3:0]        mode_i,
  input  logic [AW-1:0]     reg_val_i,
  input  logic [AW-1:0]     base_val_i,
  input  logic [AW-1:0]     idx_val_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     field_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [D_W-1:0]    elem_size_i,
  output logic [AW-1:0]     ea_o,
  output logic              imm_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_data_o,
  output logic              mem_mode_o
);
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] size_ext;
  logic [AW-1:0] reg_inc;
  logic [AW-1:0] reg_dec;

  assign disp_ext = {{(AW-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign size_ext = AW'(elem_size_i);
  assign reg_inc  = reg_val_i + size_ext;
  assign reg_dec  = reg_val_i - size_ext;

  always_comb begin
    ea_o       = field_i;
    imm_o      = 1'b0;
    wb_en_o    = 1'b0;
    wb_data_o  = reg_inc;
    mem_mode_o = 1'b0;
    unique case (mode_i)
      MODE_DIRECT:   ea_o = field_i;
      MODE_REG_IND:  ea_o = reg_val_i;
      MODE_POST_INC: begin
        ea_o      = reg_val_i;
        wb_en_o   = 1'b1;
        wb_data_o = reg_inc;
      end
      MODE_PRE_DEC: begin
        ea_o      = reg_dec;
        wb_en_o   = 1'b1;
        wb_data_o = reg_dec;
      end
      MODE_INDEXED:  ea_o = idx_val_i + disp_ext;
      MODE_BASE_IDX: ea_o = base_val_i + idx_val_i;
      MODE_PC_REL:   ea_o = pc_i + field_i;
      MODE_BASE_REL: ea_o = base_val_i + field_i;
      MODE_MEM_IND:  mem_mode_o = 1'b1;
      default:       imm_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW    = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mem_mode_i,
  input  logic [AW-1:0]    field_i,
  input  logic [AW-1:0]    calc_ea_i,
  input  logic             calc_imm_i,
  input  logic             calc_wb_i,
  input  logic [AW-1:0]    calc_wb_data_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic             mem_valid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             upd_we_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             done_o,
  output logic [AW-1:0]    ea_o,
  output logic             imm_o,
  output logic             wb_en_o,
  output logic [SEL_W-1:0] wb_sel_o,
  output logic [AW-1:0]    wb_data_o
);
  ea_state_e state_q;
  logic      accept;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign upd_we_o  = accept && !mem_mode_i && calc_wb_i;
  assign mem_req_o = (state_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mem_addr_o <= '0;
      done_o     <= 1'b0;
      ea_o       <= '0;
      imm_o      <= 1'b0;
      wb_en_o    <= 1'b0;
      wb_sel_o   <= '0;
      wb_data_o  <= '0;
    end else begin
      done_o  <= 1'b0;
      wb_en_o <= 1'b0;
      if (accept && mem_mode_i) begin
        state_q    <= ST_WAIT;
        mem_addr_o <= field_i;
      end else if (accept) begin
        done_o    <= 1'b1;
        ea_o      <= calc_ea_i;
        imm_o     <= calc_imm_i;
        wb_en_o   <= calc_wb_i;
        wb_sel_o  <= reg_sel_i;
        wb_data_o <= calc_wb_data_i;
      end else if (state_q == ST_WAIT && mem_valid_i) begin
        state_q <= ST_IDLE;
        done_o  <= 1'b1;
        ea_o    <= mem_rdata_i;
        imm_o   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NREGS  = 8,
  parameter int DISP_W = 8,
  parameter int D_W    = 4,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_we_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [AW-1:0]     ld_data_i,
  input  logic              pc_we_i,
  input  logic [AW-1:0]     pc_data_i,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [SEL_W-1:0]  base_sel_i,
  input  logic [SEL_W-1:0]  idx_sel_i,
  input  logic [AW-1:0]     addr_field_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [D_W-1:0]    elem_size_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [AW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic [AW-1:0]     ea_o,
  output logic              imm_o,
  output logic              wb_en_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  output logic [AW-1:0]     wb_data_o
);
  logic [AW-1:0] reg_val, base_val, idx_val, pc_val;
  logic [AW-1:0] calc_ea, calc_wb_data;
  logic          calc_imm, calc_wb, mem_mode, upd_we;

  ea_regfile #(.AW(AW), .NREGS(NREGS)) u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_we_i    (ld_we_i),
    .ld_sel_i   (ld_sel_i),
    .ld_data_i  (ld_data_i),
    .pc_we_i    (pc_we_i),
    .pc_data_i  (pc_data_i),
    .upd_we_i   (upd_we),
    .upd_sel_i  (reg_sel_i),
    .upd_data_i (calc_wb_data),
    .rd_a_sel_i (reg_sel_i),
    .rd_b_sel_i (base_sel_i),
    .rd_c_sel_i (idx_sel_i),
    .rd_a_o     (reg_val),
    .rd_b_o     (base_val),
    .rd_c_o     (idx_val),
    .pc_o       (pc_val)
  );

  ea_calc #(.AW(AW), .DISP_W(DISP_W), .D_W(D_W)) u_calc (
    .mode_i      (mode_i),
    .reg_val_i   (reg_val),
    .base_val_i  (base_val),
    .idx_val_i   (idx_val),
    .pc_i        (pc_val),
    .field_i     (addr_field_i),
    .disp_i      (disp_i),
    .elem_size_i (elem_size_i),
    .ea_o        (calc_ea),
    .imm_o       (calc_imm),
    .wb_en_o     (calc_wb),
    .wb_data_o   (calc_wb_data),
    .mem_mode_o  (mem_mode)
  );

  ea_ctrl #(.AW(AW), .SEL_W(SEL_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .mem_mode_i     (mem_mode),
    .field_i        (addr_field_i),
    .calc_ea_i      (calc_ea),
    .calc_imm_i     (calc_imm),
    .calc_wb_i      (calc_wb),
    .calc_wb_data_i (calc_wb_data),
    .reg_sel_i      (reg_sel_i),
    .mem_valid_i    (mem_valid_i),
    .mem_rdata_i    (mem_rdata_i),
    .upd_we_o       (upd_we),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .done_o         (done_o),
    .ea_o           (ea_o),
    .imm_o          (imm_o),
    .wb_en_o        (wb_en_o),
    .wb_sel_o       (wb_sel_o),
    .wb_data_o      (wb_data_o)
  );
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic [AW-1:0] addr_field_i,
  input logic          mem_valid_i,
  input logic [AW-1:0] mem_rdata_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          done_o,
  input logic [AW-1:0] ea_o,
  input logic          imm_o,
  input logic          wb_en_o
);
  AST_REG_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !mem_req_o && mode_i != 4'd9 |=> done_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o); // R11
  AST_WB_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> done_o); // R11
  AST_PTR_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !mem_req_o && mode_i == 4'd9 |=> mem_req_o && !done_o && mem_addr_o == $past(addr_field_i)); // R8
  AST_PTR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i |=> done_o && !mem_req_o && ea_o == $past(mem_rdata_i)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R8
  AST_WAIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o && !wb_en_o); // R12
  AST_IMM_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_o && done_o |-> !wb_en_o); // R10
endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) u_ea_unit_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mode_i       (mode_i),
  .addr_field_i (addr_field_i),
  .mem_valid_i  (mem_valid_i),
  .mem_rdata_i  (mem_rdata_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .done_o       (done_o),
  .ea_o         (ea_o),
  .imm_o        (imm_o),
  .wb_en_o      (wb_en_o)
);

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NV = 14;

  typedef struct packed {
    logic [3:0]  mode;
    logic [2:0]  sel;
    logic [2:0]  base;
    logic [2:0]  idx;
    logic [15:0] field;
    logic [7:0]  disp;
    logic [3:0]  d;
    logic [15:0] exp_ea;
    logic        exp_wb;
    logic [15:0] exp_wb_data;
    logic        exp_imm;
    logic [7:0]  req;
  } vec_t;

  // regs: r0=0 r1=1000 r2=2000 r3=3000 r4=4000 r5=5000 r6=FFFE r7=0004, pc=0100
  localparam vec_t VECS [NV] = '{
    '{4'd1, 3'd0, 3'd0, 3'd0, 16'h1234, 8'h00, 4'd0, 16'h1234, 1'b0, 16'h0000, 1'b0, 8'd1},
    '{4'd2, 3'd2, 3'd0, 3'd0, 16'h0000, 8'h00, 4'd0, 16'h2000, 1'b0, 16'h0000, 1'b0, 8'd2},
    '{4'd3, 3'd3, 3'd0, 3'd0, 16'h0000, 8'h00, 4'd2, 16'h3000, 1'b1, 16'h3002, 1'b0, 8'd3},
    '{4'd2, 3'd3, 3'd0, 3'd0, 16'h0000, 8'h00, 4'd0, 16'h3002, 1'b0, 16'h0000, 1'b0, 8'd3},
    '{4'd4, 3'd4, 3'd0, 3'd0, 16'h0000, 8'h00, 4'd4, 16'h3FFC, 1'b1, 16'h3FFC, 1'b0, 8'd4},
    '{4'd5, 3'd0, 3'd0, 3'd5, 16'h0000, 8'h80, 4'd0, 16'h4F80, 1'b0, 16'h0000, 1'b0, 8'd5},
    '{4'd5, 3'd0, 3'd0, 3'd7, 16'h0000, 8'h7F, 4'd0, 16'h0083, 1'b0, 16'h0000, 1'b0, 8'd5},
    '{4'd6, 3'd0, 3'd6, 3'd7, 16'h0000, 8'h00, 4'd0, 16'h0002, 1'b0, 16'h0000, 1'b0, 8'd6},
    '{4'd7, 3'd0, 3'd0, 3'd0, 16'h0050, 8'h00, 4'd0, 16'h0150, 1'b0, 16'h0000, 1'b0, 8'd7},
    '{4'd8, 3'd0, 3'd1, 3'd0, 16'hF000, 8'h00, 4'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 8'd9},
    '{4'd3, 3'd6, 3'd0, 3'd0, 16'h0000, 8'h00, 4'd2, 16'hFFFE, 1'b1, 16'h0000, 1'b0, 8'd9},
    '{4'd2, 3'd6, 3'd0, 3'd0, 16'h0000, 8'h00, 4'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 8'd9},
    '{4'd0, 3'd0, 3'd0, 3'd0, 16'hBEEF, 8'h00, 4'd0, 16'hBEEF, 1'b0, 16'h0000, 1'b1, 8'd10},
    '{4'd4, 3'd0, 3'd0, 3'd0, 16'h0000, 8'h00, 4'd1, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0, 8'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_we = 1'b0;
  logic [2:0]    ld_sel = '0;
  logic [AW-1:0] ld_data = '0;
  logic          pc_we = 1'b0;
  logic [AW-1:0] pc_data = '0;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [2:0]    reg_sel = '0, base_sel = '0, idx_sel = '0;
  logic [AW-1:0] field = '0;
  logic [7:0]    disp = '0;
  logic [3:0]    esize = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [AW-1:0] mem_rdata = '0;
  logic          done, imm, wb_en;
  logic [AW-1:0] ea, wb_data;
  logic [2:0]    wb_sel;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_unit u_ea_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_we_i(ld_we), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
    .pc_we_i(pc_we), .pc_data_i(pc_data),
    .start_i(start), .mode_i(mode), .reg_sel_i(reg_sel),
    .base_sel_i(base_sel), .idx_sel_i(idx_sel),
    .addr_field_i(field), .disp_i(disp), .elem_size_i(esize),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata),
    .done_o(done), .ea_o(ea), .imm_o(imm),
    .wb_en_o(wb_en), .wb_sel_o(wb_sel), .wb_data_o(wb_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_reg(input int r, input logic [AW-1:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = 3'(r); ld_data = v;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic issue(input logic [3:0] m, input logic [2:0] s, input logic [2:0] b,
                       input logic [2:0] x, input logic [15:0] f, input logic [7:0] dp,
                       input logic [3:0] dd);
    @(negedge clk);
    start = 1'b1; mode = m; reg_sel = s; base_sel = b; idx_sel = x;
    field = f; disp = dp; esize = dd;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    // R13 reset state
    chk("R13 done", 32'(done), 0);
    chk("R13 mem_req", 32'(mem_req), 0);
    chk("R13 wb_en", 32'(wb_en), 0);
    chk("R13 imm", 32'(imm), 0);
    chk("R13 ea", 32'(ea), 0);
    rst_n = 1'b1;
    issue(4'd2, 3'd5, 3'd0, 3'd0, 16'h0, 8'h0, 4'd0);
    chk("R13 reg zero after reset", 32'(ea), 0);

    load_reg(1, 16'h1000); load_reg(2, 16'h2000); load_reg(3, 16'h3000);
    load_reg(4, 16'h4000); load_reg(5, 16'h5000); load_reg(6, 16'hFFFE);
    load_reg(7, 16'h0004);
    @(negedge clk); pc_we = 1'b1; pc_data = 16'h0100;
    @(negedge clk); pc_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].mode, VECS[i].sel, VECS[i].base, VECS[i].idx,
            VECS[i].field, VECS[i].disp, VECS[i].d);
      chk($sformatf("R%0d v%0d done (R11)", VECS[i].req, i), 32'(done), 1);
      chk($sformatf("R%0d v%0d ea", VECS[i].req, i), 32'(ea), 32'(VECS[i].exp_ea));
      chk($sformatf("R%0d v%0d imm", VECS[i].req, i), 32'(imm), 32'(VECS[i].exp_imm));
      chk($sformatf("R%0d v%0d wb_en", VECS[i].req, i), 32'(wb_en), 32'(VECS[i].exp_wb));
      if (VECS[i].exp_wb) begin
        chk($sformatf("R%0d v%0d wb_data", VECS[i].req, i), 32'(wb_data), 32'(VECS[i].exp_wb_data));
        chk($sformatf("R%0d v%0d wb_sel", VECS[i].req, i), 32'(wb_sel), 32'(VECS[i].sel));
      end
      @(negedge clk);
      chk($sformatf("R11 v%0d done one cycle", i), 32'(done), 0);
    end

    // R4 / R9: r0 now FFFF after pre-decrement from zero
    issue(4'd2, 3'd0, 3'd0, 3'd0, 16'h0, 8'h0, 4'd0);
    chk("R4 r0 after decrement", 32'(ea), 32'h0000FFFF);

    // R8 / R12 memory indirect with delayed data and a competing start
    issue(4'd9, 3'd0, 3'd0, 3'd0, 16'h0A0A, 8'h0, 4'd0);
    chk("R8 mem_req raised", 32'(mem_req), 1);
    chk("R8 mem_addr", 32'(mem_addr), 32'h0A0A);
    chk("R8 no early done", 32'(done), 0);
    issue(4'd3, 3'd1, 3'd0, 3'd0, 16'h7777, 8'h0, 4'd2);
    chk("R12 start ignored, no done", 32'(done), 0);
    chk("R12 no writeback", 32'(wb_en), 0);
    chk("R8 request held", 32'(mem_req), 1);
    @(negedge clk);
    chk("R8 address held", 32'(mem_addr), 32'h0A0A);
    mem_valid = 1'b1; mem_rdata = 16'h4321;
    @(negedge clk);
    mem_valid = 1'b0; mem_rdata = 16'h0;
    chk("R8 done after data", 32'(done), 1);
    chk("R8 ea is pointer", 32'(ea), 32'h4321);
    chk("R8 request dropped", 32'(mem_req), 0);
    @(negedge clk);
    chk("R11 mem done one cycle", 32'(done), 0);
    issue(4'd2, 3'd1, 3'd0, 3'd0, 16'h0, 8'h0, 4'd0);
    chk("R12 r1 untouched by ignored start", 32'(ea), 32'h1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule